// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block derives two phase enables for a latch-based, two-phase datapath from a single fast reference clock. A slower reference input chooses which phase is wanted: its low level asks for phase one and its high level asks for phase two. The two enables are never high together. Every hand-over passes through a dead interval in which both are low, and the length of that interval is programmed in fast-clock cycles.

The slow reference is brought into the fast domain through a two-flop synchronizer before any decision uses it. A phase is raised only by an interlock that has seen the opposite phase low for the whole programmed gap. After that the phase stays high for as long as the synchronized reference keeps asking for it. Both enables come straight from flops so that no combinational glitch reaches the latches. There is no data stream, so every pin is a plain control level and no valid/ready handshake applies.

Top module: `nonovl_clkgen`

## Requirements
- R1: While `rst` is sampled high at a rising edge of `clk`, both `ph1_o` and `ph2_o` are low after that edge, and the synchronizer is cleared to a low reference.
- R2: `ph1_o` and `ph2_o` are never high in the same cycle.
- R3: Only `ph1_o` rises while the synchronized reference is low (0), and only `ph2_o` rises while it is high (1).
- R4: A change of `ref_clk_i` that is first captured at rising edge k removes the active phase at edge k+2, after two synchronizer flops.
- R5: Between the fall of one phase and the rise of the other there are exactly max(D,1) cycles in which both outputs are low, where D is the 4-bit unsigned value on `dead_cycles_i` (0 to 15). So D = 0 still gives one low cycle.
- R6: A phase rises only after the other phase has been seen low, which means only from the state in which both outputs are low.
- R7: Once high, a phase stays high for as long as the synchronized reference requests it. If the reference holds a level for L cycles, the phase that rises in that window is high for L - max(D,1) cycles.
- R8: After reset is released, both outputs stay low for max(D,1) cycles, and then the phase that the reference asks for rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock; all flops use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk_i | input | 1 | Slow phase-select reference; low asks for phase one, high asks for phase two |
| dead_cycles_i | input | 4 | Programmed dead time D in fast-clock cycles (0 is treated as 1) |
| ph1_o | output | 1 | Phase-one enable, driven from a flop |
| ph2_o | output | 1 | Phase-two enable, driven from a flop |

## Verification
The embedded properties assume that the reference holds each level for at least max(D,1)+3 fast cycles, so that every requested phase actually rises before the next change. They also assume that `dead_cycles_i` changes only while a phase is high, never during a dead interval. The stimulus changes the reference and the dead time together at the start of each segment, and each segment is made long enough for its programmed gap. Reset is applied once at start-up and once while a phase is high, so the gap before the first rise is exercised twice.

// File: rtl/nonovl_pkg.sv
package nonovl_pkg;

  typedef enum logic {
    SEL_PH1 = 1'b0,
    SEL_PH2 = 1'b1
  } phase_sel_e;

  // Decodes the synchronized reference level into the phase it asks for.
  function automatic phase_sel_e wanted_phase(input logic ref_level);
    return ref_level ? SEL_PH2 : SEL_PH1;
  endfunction

endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              both_low_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              expired_o
);

  localparam int unsigned LIM_W = DEAD_W + 1;

  logic [DEAD_W-1:0] cnt_q;
  logic [LIM_W-1:0]  limit;
  logic [LIM_W-1:0]  seen;

  // A dead time of zero still yields one low cycle.
  assign limit     = (dead_i == '0) ? LIM_W'(1) : {1'b0, dead_i};
  assign seen      = {1'b0, cnt_q} + LIM_W'(1);
  assign expired_o = both_low_i && (seen >= limit);

  always_ff @(posedge clk) begin
    if (rst || !both_low_i) cnt_q <= '0;
    else if (!expired_o)    cnt_q <= cnt_q + DEAD_W'(1);
  end

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import nonovl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_sync_i,
  input  logic gap_done_i,
  output logic both_low_o,
  output logic ph1_o,
  output logic ph2_o
);

  logic       ph1_q, ph2_q;
  phase_sel_e want;

  assign want       = wanted_phase(ref_sync_i);
  assign both_low_o = !ph1_q && !ph2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph1_q <= 1'b0;
      ph2_q <= 1'b0;
    end else if (ph1_q && want != SEL_PH1) begin
      ph1_q <= 1'b0;
    end else if (ph2_q && want != SEL_PH2) begin
      ph2_q <= 1'b0;
    end else if (both_low_o && gap_done_i) begin
      ph1_q <= (want == SEL_PH1);
      ph2_q <= (want == SEL_PH2);
    end
  end

  assign ph1_o = ph1_q;
  assign ph2_o = ph2_q;

  // R2: the enables never overlap
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(ph1_q && ph2_q));

  // R3: a rising phase matches the reference level it saw
  p_select_ph1_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ph1_q) |-> !$past(ref_sync_i));
  p_select_ph2_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ph2_q) |-> $past(ref_sync_i));

  // R4: a reference that no longer asks for the active phase removes it
  p_drop_ph1_r4: assert property (@(posedge clk) disable iff (rst)
    (ph1_q && ref_sync_i) |=> !ph1_q);

  // R6: a phase rises only after the other one has been seen low
  p_interlock_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ph1_q) || $rose(ph2_q)) |-> $past(!ph1_q && !ph2_q));

  // R7: a requested phase holds
  p_hold_ph2_r7: assert property (@(posedge clk) disable iff (rst)
    (ph2_q && ref_sync_i) |=> ph2_q);

endmodule

// File: rtl/nonovl_clkgen.sv
module nonovl_clkgen #(
  parameter int unsigned DEAD_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk_i,
  input  logic [DEAD_W-1:0] dead_cycles_i,
  output logic              ph1_o,
  output logic              ph2_o
);

  logic ref_s;
  logic both_low;
  logic gap_done;

  ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ref_clk_i),
    .sync_o  (ref_s)
  );

  gap_timer #(.DEAD_W(DEAD_W)) u_gap (
    .clk        (clk),
    .rst        (rst),
    .both_low_i (both_low),
    .dead_i     (dead_cycles_i),
    .expired_o  (gap_done)
  );

  phase_ctrl u_phase (
    .clk        (clk),
    .rst        (rst),
    .ref_sync_i (ref_s),
    .gap_done_i (gap_done),
    .both_low_o (both_low),
    .ph1_o      (ph1_o),
    .ph2_o      (ph2_o)
  );

endmodule

// File: tb/nonovl_clkgen_tb_top.sv
module nonovl_clkgen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  typedef struct {
    int  phase;   // 1 or 2
    int  gap;     // expected low cycles before the rise
    int  high;    // expected high cycles
    bit  first;   // first rise after reset
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk = 1'b0;
  logic [3:0] dead = 4'd0;
  logic       ph1, ph2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nonovl_clkgen dut_i (
    .clk           (clk),
    .rst           (rst),
    .ref_clk_i     (ref_clk),
    .dead_cycles_i (dead),
    .ph1_o         (ph1),
    .ph2_o         (ph2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim_of(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // Driver: start one reference segment and push what it must produce.
  task automatic seg(input bit lvl, input int d, input int len, input bit first);
    exp_t e;
    @(posedge clk); #1;
    ref_clk = lvl;
    dead    = 4'(d);
    if (first) rst = 1'b0;
    e.phase = lvl ? 2 : 1;
    e.gap   = lim_of(d);
    e.high  = first ? (len + 3 - lim_of(d)) : (len - lim_of(d));
    e.first = first;
    exp_q.push_back(e);
    repeat (len - 1) @(posedge clk);
  endtask

  task automatic do_reset;
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ph1 && !ph2, "R1", {30'd0, ph2, ph1}, 0);
    exp_q.delete();
  endtask

  // Monitor: pops one expected item at each rise and compares it.
  int   gap_n = 0;
  int   run_n = 0;
  bit   p1 = 1'b0, p2 = 1'b0;
  bit   cur_v = 1'b0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst) begin
      gap_n = 0; run_n = 0; p1 = 1'b0; p2 = 1'b0; cur_v = 1'b0;
    end else begin
      chk(!(ph1 && ph2), "R2", {30'd0, ph2, ph1}, 0);
      if (!ph1 && !ph2) begin
        if (p1 || p2) begin
          if (cur_v) chk(run_n == cur.high, "R7/R4 high length", run_n, cur.high);
          cur_v = 1'b0;
          gap_n = 1;
        end else begin
          gap_n++;
        end
      end else if (!p1 && !p2) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected rise", 1, 0);
        end else begin
          cur   = exp_q.pop_front();
          cur_v = 1'b1;
          chk((cur.phase == 1) ? (ph1 && !ph2) : (ph2 && !ph1), "R3",
              ph1 ? 1 : 2, cur.phase);
          chk(gap_n == cur.gap, cur.first ? "R8" : "R5/R6", gap_n, cur.gap);
          run_n = 1;
        end
      end else begin
        run_n++;
      end
      p1 = ph1;
      p2 = ph2;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ph1 && !ph2, "R1", {30'd0, ph2, ph1}, 0);
    seg(1'b0, 0, 6, 1'b1);
    seg(1'b1, 0, 5, 1'b0);
    seg(1'b0, 3, 8, 1'b0);
    seg(1'b1, 15, 20, 1'b0);
    seg(1'b0, 15, 18, 1'b0);
    seg(1'b1, 1, 4, 1'b0);
    seg(1'b0, 7, 12, 1'b0);
    do_reset();
    seg(1'b0, 5, 10, 1'b1);
    seg(1'b1, 2, 6, 1'b0);
    seg(1'b0, 0, 4, 1'b0);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 missing rise", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", MAX_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule